// File: doc/BRIEF.md
# Page-Buffered Flash Write Controller

This block stands between a small processor's external-data write bus, its code-fetch bus and an on-chip flash store. Software first sets a latch-enable bit in the control register. Data writes to the lower half of the address space (bit 15 clear) then stop going to external RAM. They land in a one-page staging buffer of 128 bytes, and each written byte is marked as loaded. A two-write key sequence on the control register starts a programming run. The run copies the loaded bytes into the target chosen by a 2-bit field: the user array, a 128-byte extra row, or the upper nibble of a security byte. The lower nibble of the security byte is reachable only through a separate hardware port.

A run lasts a fixed number of cycles and is reported by a busy bit. While busy, staging writes and control writes are dropped. Code reads of the array being programmed return FFh. When the run ends, the buffer returns to FFh and every loaded mark is cleared. Code fetches can also be steered to an external boot store: when the boot-enable input is high, fetches at or above F400h are routed there.

A control FSM sequences these steps through three states:
- ST_IDLE to ST_ARMED on a control write with key nibble 5h.
- ST_ARMED to ST_PROG on a control write with key nibble Ah.
- ST_ARMED to ST_IDLE on any other control write. This is the abort path.
- ST_PROG to ST_IDLE once the cycle counter reaches PROG_CYC-1. In that cycle the commit happens.

The storage model is a register array of 2^PG_W pages, reset to FFh.

Top module: `pgf_ctrl`

## Requirements
- R1: After reset the control read-back (ctl_rdata) is 00h. Code reads of the array, extra-row reads and the security byte all read FFh.
- R2: Outside a key sequence, a control write with key nibble (bits 7:4) other than 5h loads the two fields. Bit 0 is the latch enable. Bits 2:1 are the target: 00 user array, 01 extra row, 10 security byte. ctl_rdata returns {4'b0, busy, target, enable}.
- R3: With the latch enable set, a data write with xw_addr[15]=0 goes to the staging buffer and xram_we stays low, even when xram_sel is high. Any other write asserts xram_we exactly when xram_sel is high.
- R4: A control write with key 5h followed by a control write with key Ah starts a run. The second write also loads the fields. Busy (ctl_rdata bit 3) reads 1 for exactly PROG_CYC cycles after the starting write, then 0.
- R5: After key 5h, a control write with any key other than Ah aborts. No run starts and the fields keep their values.
- R6: A run to the user array writes each loaded byte to page (xw_addr[PG_W+6:7] of the last staging write) at offset xw_addr[6:0]. Bytes that were not loaded keep their old value.
- R7: After a run, the buffer and its loaded marks are cleared, so a later run changes only the bytes loaded since then.
- R8: A run with target 01 writes the loaded bytes into the extra row, read through xr_addr/xr_rdata. It leaves the user array untouched.
- R9: A run with target 10 writes bits 7:4 of buffer byte 0 into bits 7:4 of the security byte. Bits 3:0 of the security byte change only through hw_sec_we/hw_sec_data.
- R10: While busy, control writes and staging writes have no effect.
- R11: While a user-array run is busy, code reads inside the array return FFh. Afterwards they return the stored data.
- R12: With boot_en high, a code read at an address of F400h or above returns boot_rdata. With boot_en low, or below F400h, the read takes the array path, and addresses beyond the array read FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xw_en | input | 1 | External-data write strobe |
| xw_addr | input | 16 | External-data write address |
| xw_data | input | 8 | External-data write byte |
| xram_sel | input | 1 | External-RAM select |
| xram_we | output | 1 | Write forwarded to external RAM |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value (key, target, enable) |
| ctl_rdata | output | 8 | Control/status read-back |
| cr_addr | input | 16 | Code-read address |
| cr_rdata | output | 8 | Code-read data |
| boot_en | input | 1 | Boot-window enable |
| boot_rdata | input | 8 | Data from the external boot store |
| xr_addr | input | 7 | Extra-row read offset |
| xr_rdata | output | 8 | Extra-row read data |
| hw_sec_we | input | 1 | Hardware-port strobe for the security low nibble |
| hw_sec_data | input | 4 | Hardware-port value for the security low nibble |
| sec_rdata | output | 8 | Security byte |

## Verification
A stuck FSM state shows on ctl_rdata bit 3 within one cycle of the starting write. A counter off by one shows as a busy run one cycle too long or too short. A lost or stale loaded mark, a wrong page capture or a wrong target decode only becomes visible after the commit cycle, as wrong bytes in the array, the extra row or the security byte. The bench therefore reads back the neighbours of every written byte. A wrong overlay decode appears at once on xram_we in the same cycle as the write.

// File: rtl/pgf_pkg.sv
`timescale 1ns/1ps
package pgf_pkg;
    typedef enum logic [1:0] {
        TGT_USER = 2'd0,
        TGT_XROW = 2'd1,
        TGT_SEC  = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PROG  = 2'd2
    } st_e;

    localparam logic [3:0] KEY_ARM = 4'h5;
    localparam logic [3:0] KEY_GO  = 4'hA;
    localparam logic [7:0] ERASED  = 8'hFF;
endpackage

// File: rtl/pgf_keyfsm.sv
`timescale 1ns/1ps
module pgf_keyfsm
    import pgf_pkg::*;
#(
    parameter int PROG_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    output logic       lat_en,
    output tgt_e       tgt,
    output logic       busy,
    output logic       commit
);
    localparam int CNT_W = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;

    st_e              st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             ld_fields;
    logic             last;
    logic [3:0]       key;

    assign key  = ctl_wdata[7:4];
    assign last = (cnt_q == CNT_W'(PROG_CYC - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (ctl_we && key == KEY_ARM) st_d = ST_ARMED;
            ST_ARMED: if (ctl_we) st_d = (key == KEY_GO) ? ST_PROG : ST_IDLE;
            ST_PROG:  if (last) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        commit    = 1'b0;
        ld_fields = 1'b0;
        unique case (st_q)
            ST_IDLE:  ld_fields = ctl_we && (key != KEY_ARM);
            ST_ARMED: ld_fields = ctl_we && (key == KEY_GO);
            ST_PROG: begin
                busy   = 1'b1;
                commit = last;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_en <= 1'b0;
            tgt    <= TGT_USER;
        end else if (ld_fields) begin
            lat_en <= ctl_wdata[0];
            tgt    <= tgt_e'(ctl_wdata[2:1]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || st_q != ST_PROG) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pgf_latch.sv
`timescale 1ns/1ps
module pgf_latch
    import pgf_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int PG_W       = 4,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [OFF_W-1:0]        off,
    input  logic [PG_W-1:0]         pg,
    input  logic [7:0]              din,
    input  logic                    clr,
    output logic [PAGE_BYTES*8-1:0] pbuf,
    output logic [PAGE_BYTES-1:0]   loaded,
    output logic [PG_W-1:0]         pg_q
);
    for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                pbuf[b*8 +: 8] <= ERASED;
                loaded[b]      <= 1'b0;
            end else if (wr && off == OFF_W'(b)) begin
                pbuf[b*8 +: 8] <= din;
                loaded[b]      <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  pg_q <= '0;
        else if (wr) pg_q <= pg;
    end
endmodule

// File: rtl/pgf_store.sv
`timescale 1ns/1ps
module pgf_store
    import pgf_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int PG_W       = 4,
    parameter int OFF_W      = $clog2(PAGE_BYTES),
    parameter int ARR_W      = PG_W + OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  tgt_e                    tgt,
    input  logic [PAGE_BYTES*8-1:0] pbuf,
    input  logic [PAGE_BYTES-1:0]   loaded,
    input  logic [PG_W-1:0]         pg,
    input  logic                    hw_sec_we,
    input  logic [3:0]              hw_sec_data,
    input  logic [ARR_W-1:0]        rd_idx,
    input  logic [OFF_W-1:0]        xr_idx,
    output logic [7:0]              arr_rdata,
    output logic [7:0]              xr_rdata,
    output logic [7:0]              sec_q
);
    localparam int ARR_BYTES = 1 << ARR_W;

    logic [7:0] arr  [ARR_BYTES];
    logic [7:0] xrow [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARR_BYTES; i++) arr[i] <= ERASED;
        end else if (commit && tgt == TGT_USER) begin
            for (int b = 0; b < PAGE_BYTES; b++)
                if (loaded[b]) arr[{pg, OFF_W'(b)}] <= pbuf[b*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) xrow[i] <= ERASED;
        end else if (commit && tgt == TGT_XROW) begin
            for (int b = 0; b < PAGE_BYTES; b++)
                if (loaded[b]) xrow[b] <= pbuf[b*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= ERASED;
        end else begin
            if (commit && tgt == TGT_SEC && loaded[0]) sec_q[7:4] <= pbuf[7:4];
            if (hw_sec_we) sec_q[3:0] <= hw_sec_data;
        end
    end

    assign arr_rdata = arr[rd_idx];
    assign xr_rdata  = xrow[xr_idx];
endmodule

// File: rtl/pgf_ctrl.sv
`timescale 1ns/1ps
module pgf_ctrl
    import pgf_pkg::*;
#(
    parameter int          PAGE_BYTES = 128,
    parameter int          PG_W       = 4,
    parameter int          PROG_CYC   = 8,
    parameter logic [15:0] BOOT_BASE  = 16'hF400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xw_en,
    input  logic [15:0] xw_addr,
    input  logic [7:0]  xw_data,
    input  logic        xram_sel,
    output logic        xram_we,
    input  logic        ctl_we,
    input  logic [7:0]  ctl_wdata,
    output logic [7:0]  ctl_rdata,
    input  logic [15:0] cr_addr,
    output logic [7:0]  cr_rdata,
    input  logic        boot_en,
    input  logic [7:0]  boot_rdata,
    input  logic [$clog2(PAGE_BYTES)-1:0] xr_addr,
    output logic [7:0]  xr_rdata,
    input  logic        hw_sec_we,
    input  logic [3:0]  hw_sec_data,
    output logic [7:0]  sec_rdata
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int ARR_W = PG_W + OFF_W;

    logic                    lat_en, busy, commit;
    tgt_e                    tgt;
    logic                    ovl_hit, lat_wr, boot_hit, in_arr;
    logic [PAGE_BYTES*8-1:0] pbuf;
    logic [PAGE_BYTES-1:0]   loaded;
    logic [PG_W-1:0]         pg_q;
    logic [7:0]              arr_rdata, xr_raw;

    if (ARR_W < 15) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^xw_addr[14:ARR_W];
    end

    pgf_keyfsm #(.PROG_CYC(PROG_CYC)) fsm_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .lat_en(lat_en), .tgt(tgt), .busy(busy), .commit(commit)
    );

    // overlay decode: the latch window wins over the external-RAM select
    assign ovl_hit = lat_en && !xw_addr[15];
    assign lat_wr  = xw_en && ovl_hit && !busy;
    assign xram_we = xw_en && xram_sel && !ovl_hit;

    pgf_latch #(.PAGE_BYTES(PAGE_BYTES), .PG_W(PG_W), .OFF_W(OFF_W)) lat_i (
        .clk(clk), .rst_n(rst_n), .wr(lat_wr),
        .off(xw_addr[OFF_W-1:0]), .pg(xw_addr[OFF_W +: PG_W]), .din(xw_data),
        .clr(commit), .pbuf(pbuf), .loaded(loaded), .pg_q(pg_q)
    );

    pgf_store #(.PAGE_BYTES(PAGE_BYTES), .PG_W(PG_W), .OFF_W(OFF_W), .ARR_W(ARR_W)) st_i (
        .clk(clk), .rst_n(rst_n), .commit(commit), .tgt(tgt),
        .pbuf(pbuf), .loaded(loaded), .pg(pg_q),
        .hw_sec_we(hw_sec_we), .hw_sec_data(hw_sec_data),
        .rd_idx(cr_addr[ARR_W-1:0]), .xr_idx(xr_addr),
        .arr_rdata(arr_rdata), .xr_rdata(xr_raw), .sec_q(sec_rdata)
    );

    assign boot_hit = boot_en && (cr_addr >= BOOT_BASE);
    assign in_arr   = (cr_addr[15:ARR_W] == '0);

    always_comb begin
        if (boot_hit)                          cr_rdata = boot_rdata;
        else if (!in_arr)                      cr_rdata = ERASED;
        else if (busy && tgt == TGT_USER)      cr_rdata = ERASED;
        else                                   cr_rdata = arr_rdata;
    end

    assign xr_rdata  = (busy && tgt == TGT_XROW) ? ERASED : xr_raw;
    assign ctl_rdata = {4'b0000, busy, tgt, lat_en};
endmodule

// File: rtl/pgf_ctrl_chk.sv
`timescale 1ns/1ps
module pgf_ctrl_chk #(
    parameter int          PROG_CYC  = 8,
    parameter int          ARR_W     = 11,
    parameter logic [15:0] BOOT_BASE = 16'hF400
) (
    input logic        clk,
    input logic        rst_n,
    input logic        xw_en,
    input logic [15:0] xw_addr,
    input logic        xram_we,
    input logic [7:0]  ctl_rdata,
    input logic [15:0] cr_addr,
    input logic [7:0]  cr_rdata,
    input logic        boot_en,
    input logic [7:0]  boot_rdata,
    input logic        hw_sec_we,
    input logic [7:0]  sec_rdata
);
    logic        busy;
    logic [15:0] run;
    assign busy = ctl_rdata[3];

    always_ff @(posedge clk) begin
        if (!rst_n)    run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    p_overlay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xw_en && ctl_rdata[0] && !xw_addr[15]) |-> !xram_we);

    p_busy_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run < 16'(PROG_CYC)));

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> ($past(run) == 16'(PROG_CYC - 1)));

    p_fields_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(ctl_rdata[2:0]));

    p_erased_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_rdata[2:1] == 2'b00 && cr_addr[15:ARR_W] == '0 &&
         !(boot_en && cr_addr >= BOOT_BASE)) |-> (cr_rdata == 8'hFF));

    p_sec_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_sec_we |=> $stable(sec_rdata[3:0]));

    p_boot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_en && cr_addr >= BOOT_BASE) |-> (cr_rdata == boot_rdata));
endmodule

bind pgf_ctrl pgf_ctrl_chk #(.PROG_CYC(PROG_CYC), .ARR_W(ARR_W), .BOOT_BASE(BOOT_BASE)) chk_i (
    .clk(clk), .rst_n(rst_n), .xw_en(xw_en), .xw_addr(xw_addr), .xram_we(xram_we),
    .ctl_rdata(ctl_rdata), .cr_addr(cr_addr), .cr_rdata(cr_rdata),
    .boot_en(boot_en), .boot_rdata(boot_rdata), .hw_sec_we(hw_sec_we),
    .sec_rdata(sec_rdata)
);

// File: tb/pgf_ctrl_tb_top.sv
`timescale 1ns/1ps
module pgf_ctrl_tb_top;
    localparam int PROG_CYC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xw_en = 1'b0;
    logic [15:0] xw_addr = '0;
    logic [7:0]  xw_data = '0;
    logic        xram_sel = 1'b0;
    logic        xram_we;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic [15:0] cr_addr = '0;
    logic [7:0]  cr_rdata;
    logic        boot_en = 1'b0;
    logic [7:0]  boot_rdata = 8'hC3;
    logic [6:0]  xr_addr = '0;
    logic [7:0]  xr_rdata;
    logic        hw_sec_we = 1'b0;
    logic [3:0]  hw_sec_data = '0;
    logic [7:0]  sec_rdata;

    always #2 clk = ~clk;

    pgf_ctrl #(.PROG_CYC(PROG_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .xw_en(xw_en), .xw_addr(xw_addr), .xw_data(xw_data),
        .xram_sel(xram_sel), .xram_we(xram_we), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .cr_addr(cr_addr), .cr_rdata(cr_rdata),
        .boot_en(boot_en), .boot_rdata(boot_rdata), .xr_addr(xr_addr),
        .xr_rdata(xr_rdata), .hw_sec_we(hw_sec_we), .hw_sec_data(hw_sec_data),
        .sec_rdata(sec_rdata)
    );

    // src: 0 code read, 1 control, 2 extra row, 3 security, 4 xram_we
    typedef struct {
        int         src;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // monitor: every item pushed in the previous cycle is due now
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t      it;
            logic [7:0] got;
            it = q.pop_front();
            case (it.src)
                0: got = cr_rdata;
                1: got = ctl_rdata;
                2: got = xr_rdata;
                3: got = sec_rdata;
                default: got = {7'b0, xram_we};
            endcase
            n_vec++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s src=%0d actual=%02h expected=%02h", it.req, it.src, got, it.exp);
            end
        end
    end

    task automatic push(input int src, input logic [7:0] exp, input string req);
        item_t it;
        it.src = src; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic tick();
        @(negedge clk); #1;
        xw_en = 1'b0; ctl_we = 1'b0; hw_sec_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
        cr_addr = a; push(0, exp, req); tick();
    endtask

    task automatic chk(input int src, input logic [7:0] exp, input string req);
        push(src, exp, req); tick();
    endtask

    task automatic xwr(input logic [15:0] a, input logic [7:0] d, input logic xe, input string req);
        xw_en = 1'b1; xw_addr = a; xw_data = d; push(4, {7'b0, xe}, req); tick();
    endtask

    task automatic ctlw(input logic [7:0] d);
        ctl_we = 1'b1; ctl_wdata = d; tick();
    endtask

    task automatic launch(input logic [1:0] t, input bit poke);
        logic [7:0] f;
        f = {5'b0, t, 1'b1};
        ctlw(8'h50 | f);
        ctl_we = 1'b1; ctl_wdata = 8'hA0 | f;
        push(1, f | 8'h08, "R4 busy rises");
        tick();
        for (int i = 1; i < PROG_CYC; i++) begin
            if (poke && i == 1) begin
                ctl_we = 1'b1; ctl_wdata = 8'h00;
                xw_en = 1'b1; xw_addr = 16'h0201; xw_data = 8'h88;
                cr_addr = 16'h0185;
                push(0, 8'hFF, "R11 array erased while busy");
                push(4, 8'h00, "R3 overlay while busy");
            end
            push(1, f | 8'h08, "R4/R10 busy held, fields frozen");
            tick();
        end
        push(1, f, "R4 busy falls");
        tick();
    endtask

    initial begin
        xram_sel = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        chk(1, 8'h00, "R1 control");
        rd(16'h0000, 8'hFF, "R1 array");
        rd(16'h0185, 8'hFF, "R1 array");
        xr_addr = 7'd7; chk(2, 8'hFF, "R1 extra row");
        chk(3, 8'hFF, "R1 security");
        // R3 without overlay
        xwr(16'h0010, 8'h01, 1'b1, "R3 xram path");
        // R2 field writes
        ctlw(8'h05); chk(1, 8'h05, "R2 fields");
        ctlw(8'h01); chk(1, 8'h01, "R2 fields");
        // R3 overlay, page 3 bytes 5 and 6
        xwr(16'h0185, 8'h5A, 1'b0, "R3 overlay");
        xwr(16'h0186, 8'hA5, 1'b0, "R3 overlay");
        xwr(16'h9000, 8'h00, 1'b1, "R3 upper half to xram");
        // R6 user program
        launch(2'd0, 1'b0);
        rd(16'h0185, 8'h5A, "R6 loaded byte");
        rd(16'h0186, 8'hA5, "R6 loaded byte");
        rd(16'h0184, 8'hFF, "R6 unloaded byte");
        rd(16'h0187, 8'hFF, "R6 unloaded byte");
        // R7 only new loads commit
        xwr(16'h0184, 8'h11, 1'b0, "R3 overlay");
        launch(2'd0, 1'b0);
        rd(16'h0184, 8'h11, "R7 new byte");
        rd(16'h0185, 8'h5A, "R7 old byte kept");
        rd(16'h0186, 8'hA5, "R7 old byte kept");
        // R5 abort
        xwr(16'h0187, 8'h22, 1'b0, "R3 overlay");
        ctlw(8'h51);
        ctlw(8'h32);
        chk(1, 8'h01, "R5 abort keeps fields, not busy");
        for (int i = 0; i < PROG_CYC + 2; i++) tick();
        chk(1, 8'h01, "R5 no run started");
        rd(16'h0187, 8'hFF, "R5 nothing committed");
        // R8 extra row gets the still-loaded byte
        launch(2'd1, 1'b0);
        xr_addr = 7'd7; chk(2, 8'h22, "R8 extra row byte");
        xr_addr = 7'd0; chk(2, 8'hFF, "R8 extra row unloaded");
        rd(16'h0187, 8'hFF, "R8 array untouched");
        // R9 security byte
        hw_sec_we = 1'b1; hw_sec_data = 4'h6; tick();
        chk(3, 8'hF6, "R9 hw nibble");
        xwr(16'h0180, 8'h3C, 1'b0, "R3 overlay");
        launch(2'd2, 1'b0);
        chk(3, 8'h36, "R9 upper nibble from buffer, lower kept");
        // R10 / R11 pokes during busy
        xwr(16'h0200, 8'h77, 1'b0, "R3 overlay");
        launch(2'd0, 1'b1);
        rd(16'h0200, 8'h77, "R10 loaded byte");
        rd(16'h0201, 8'hFF, "R10 busy write dropped");
        rd(16'h0185, 8'h5A, "R11 data back after run");
        chk(1, 8'h01, "R10 control write dropped");
        // R12 boot window
        boot_en = 1'b1;
        rd(16'hF400, 8'hC3, "R12 boot base");
        rd(16'hFFFF, 8'hC3, "R12 boot top");
        rd(16'hF3FF, 8'hFF, "R12 below window");
        rd(16'h0185, 8'h5A, "R12 array path");
        boot_en = 1'b0;
        rd(16'hF400, 8'hFF, "R12 window off");
        tick(); tick();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule